// File: doc/BRIEF.md
# CPU Performance-Level Selector with Settling Ramp

This block picks the CPU clock source, divider and clock-select bit from one of four performance levels. Level 0 is the fastest and level 3 the slowest. Each level is described by a 16-bit descriptor held in one of two 32-bit configuration words. When dynamic mode is off, the outputs come from static source, divider and select inputs.

A requester asks for a divider value. The block scans the four levels and switches to the lowest-numbered level whose divider matches. If no level matches, or dynamic mode is off, the request is rejected. A one-cycle pulse reports the result either way.

A settling rule guards the fastest level. It applies when both the base clock and the requested rate are flagged as fast (at least 1 GHz). In that case, reaching level 0 without a completed dwell at level 1 first parks the CPU at level 1 for a programmable number of cycles, then moves it on to level 0. During that dwell the block is busy and does not accept new requests. The voltage regulator, the PLL and the glitch-free clock switch lie outside the block.

Top module: `dvfs_level_ctrl`

## Requirements
- R1: While `rst_n` is low and on release, the level is 0, `busy_o`, `done_o` and `err_o` are 0, and no dwell is tracked.
- R2: With `dyn_en` high, the outputs carry the descriptor of the current level. Levels 0 and 1 come from `cfg_hi_word` and levels 2 and 3 from `cfg_lo_word`. Even levels use bits [31:16] and odd levels bits [15:0]. Within a 16-bit half, the divider is bits [15:13], the select bit is bit 11 and the source is bits [10:9]; all other bits are ignored.
- R3: With `dyn_en` low, `src_o`, `div_o` and `sel_o` equal `static_src`, `static_div` and `static_sel`.
- R4: An accepted request goes to the lowest-numbered level whose divider equals `req_div`. The level changes, and `done_o` pulses, in the cycle after acceptance.
- R5: A request with `dyn_en` low, or one that matches no level, pulses `err_o` one cycle after acceptance and leaves the level unchanged.
- R6: A request that matches the current level pulses `done_o` and changes nothing.
- R7: Entering level 1 from level 0 marks the dwell as satisfied. Entering level 1 from level 2 or 3 starts a dwell that is satisfied after `dwell_cycles` cycles.
- R8: A move to level 0 with `base_fast` and `rate_fast` both high and the dwell not satisfied works as follows. The block sets level 1 and holds `busy_o` high for exactly `dwell_cycles` cycles. It then sets level 0 and pulses `done_o`.
- R9: A move to level 0 in any other case takes effect directly in the next cycle, with no busy period.
- R10: While `busy_o` is high, `req_valid` is not accepted. A request held high is taken in the first cycle after `busy_o` falls.
- R11: A move to level 2 or 3, or a completed move to level 0, clears the dwell. A later fast move to level 0 then needs a new ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dyn_en | input | 1 | Dynamic mode enable (mode register bit 31) |
| cfg_hi_word | input | 32 | Descriptors of levels 0 (upper half) and 1 (lower half) |
| cfg_lo_word | input | 32 | Descriptors of levels 2 (upper half) and 3 (lower half) |
| static_src | input | 2 | Source used when dynamic mode is off |
| static_div | input | 3 | Divider used when dynamic mode is off |
| static_sel | input | 1 | Clock-select bit used when dynamic mode is off |
| base_fast | input | 1 | Base clock is at least 1 GHz |
| rate_fast | input | 1 | Requested rate is at least 1 GHz |
| req_valid | input | 1 | Divider request, held until accepted |
| req_div | input | 3 | Requested divider |
| dwell_cycles | input | CNT_W | Dwell length in clock cycles |
| lvl_o | output | 2 | Current level |
| src_o | output | 2 | Selected clock source |
| div_o | output | 3 | Selected divider |
| sel_o | output | 1 | Selected clock-select bit |
| busy_o | output | 1 | Settling dwell in progress |
| done_o | output | 1 | Request completed (one-cycle pulse) |
| err_o | output | 1 | Request rejected (one-cycle pulse) |

## Verification
A corrupted dwell tracker shows up on the next fast request for level 0. The block then either opens a busy window that should not exist or skips one that should, so the fault appears at `busy_o` and `lvl_o` one cycle after that request. A dwell counter that is off by one shows up as a busy window one cycle too long or too short. A wrong level register shows up at once on `src_o`/`div_o`/`sel_o`, because these decode the level combinationally. The bench compares every output against a behavioural model on every cycle, so any such fault is caught within the first cycle it reaches a port.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
  localparam int NUM_LVL = 4;
  localparam int LVL_W   = $clog2(NUM_LVL);
  localparam int DIV_W   = 3;
  localparam int SRC_W   = 2;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int DIV_POS = 13;
  localparam int SEL_POS = 11;
  localparam int SRC_POS = 9;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [SRC_W-1:0] src;
    logic             sel;
  } clk_cfg_t;

  typedef enum logic [1:0] {TRK_NONE, TRK_RUN, TRK_OK} trk_t;

  // Even levels sit in the upper half of their word.
  function automatic logic lvl_upper(input int lvl);
    return (lvl % 2) == 0;
  endfunction

  function automatic clk_cfg_t unpack_desc(input logic [WORD_W-1:0] word, input logic upper);
    clk_cfg_t d;
    int base;
    base  = upper ? HALF_W : 0;
    d.div = word[base+DIV_POS +: DIV_W];
    d.src = word[base+SRC_POS +: SRC_W];
    d.sel = word[base+SEL_POS];
    return d;
  endfunction
endpackage

// File: rtl/dvfs_desc_bank.sv
module dvfs_desc_bank
  import dvfs_sel_pkg::*;
(
  input  logic [WORD_W-1:0]          hi_word,
  input  logic [WORD_W-1:0]          lo_word,
  output clk_cfg_t [NUM_LVL-1:0]     desc_o
);
  localparam int PER_WORD = 2;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    if (g < PER_WORD) begin : g_hi
      assign desc_o[g] = unpack_desc(hi_word, lvl_upper(g));
    end else begin : g_lo
      assign desc_o[g] = unpack_desc(lo_word, lvl_upper(g));
    end
  end

  logic unused_word_bits;
  assign unused_word_bits = ^{hi_word, lo_word};
endmodule

// File: rtl/dvfs_match_scan.sv
module dvfs_match_scan
  import dvfs_sel_pkg::*;
(
  input  clk_cfg_t [NUM_LVL-1:0] desc_i,
  input  logic [DIV_W-1:0]       div_i,
  output logic                   hit_o,
  output logic [LVL_W-1:0]       lvl_o
);
  // Scan from the slowest level down so the lowest index wins.
  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int i = NUM_LVL-1; i >= 0; i--) begin
      if (desc_i[i].div == div_i) begin
        hit_o = 1'b1;
        lvl_o = LVL_W'(i);
      end
    end
  end
endmodule

// File: rtl/dvfs_dwell_timer.sv
module dvfs_dwell_timer
  import dvfs_sel_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mark_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] dwell_i,
  output logic             ok_o,
  output logic             expire_o
);
  trk_t             trk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = (trk_q == TRK_RUN) && (cnt_inc >= {1'b0, dwell_i});
  assign ok_o     = (trk_q == TRK_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trk_q <= TRK_NONE;
      cnt_q <= '0;
    end else if (clear_i) begin
      trk_q <= TRK_NONE;
    end else if (start_i) begin
      trk_q <= TRK_RUN;
      cnt_q <= '0;
    end else if (mark_i || expire_o) begin
      trk_q <= TRK_OK;
    end else if (trk_q == TRK_RUN) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  // R7
  ok_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_q == TRK_OK && $past(trk_q) != TRK_OK) |-> ($past(mark_i) || $past(expire_o)));

  // R7
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> (trk_q == TRK_RUN && cnt_q == '0));
endmodule

// File: rtl/dvfs_out_sel.sv
module dvfs_out_sel
  import dvfs_sel_pkg::*;
(
  input  logic                   dyn_en,
  input  logic [LVL_W-1:0]       lvl_i,
  input  clk_cfg_t [NUM_LVL-1:0] desc_i,
  input  logic [SRC_W-1:0]       st_src,
  input  logic [DIV_W-1:0]       st_div,
  input  logic                   st_sel,
  output logic [SRC_W-1:0]       src_o,
  output logic [DIV_W-1:0]       div_o,
  output logic                   sel_o
);
  clk_cfg_t cur;

  always_comb begin
    if (dyn_en) begin
      cur = desc_i[lvl_i];
    end else begin
      cur.div = st_div;
      cur.src = st_src;
      cur.sel = st_sel;
    end
  end

  assign src_o = cur.src;
  assign div_o = cur.div;
  assign sel_o = cur.sel;
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
  import dvfs_sel_pkg::*;
#(
  parameter int CNT_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dyn_en,
  input  logic [31:0]       cfg_hi_word,
  input  logic [31:0]       cfg_lo_word,
  input  logic [1:0]        static_src,
  input  logic [2:0]        static_div,
  input  logic              static_sel,
  input  logic              base_fast,
  input  logic              rate_fast,
  input  logic              req_valid,
  input  logic [2:0]        req_div,
  input  logic [CNT_W-1:0]  dwell_cycles,
  output logic [1:0]        lvl_o,
  output logic [1:0]        src_o,
  output logic [2:0]        div_o,
  output logic              sel_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(0);
  localparam logic [LVL_W-1:0] LVL_MID = LVL_W'(1);

  typedef enum logic {ST_IDLE, ST_RAMP} st_t;

  st_t              st_q;
  logic [LVL_W-1:0] lvl_q;
  logic             done_q, err_q;

  clk_cfg_t [NUM_LVL-1:0] descs;
  logic             hit;
  logic [LVL_W-1:0] hit_lvl;
  logic             tmr_ok, tmr_expire;

  // Named events
  logic accept, ev_reject, ev_same, ev_go;
  logic ramp_needed, ramp_finish;
  logic tmr_start, tmr_mark, tmr_clear;

  dvfs_desc_bank u_bank (
    .hi_word (cfg_hi_word),
    .lo_word (cfg_lo_word),
    .desc_o  (descs)
  );

  dvfs_match_scan u_scan (
    .desc_i (descs),
    .div_i  (req_div),
    .hit_o  (hit),
    .lvl_o  (hit_lvl)
  );

  assign accept      = req_valid && (st_q == ST_IDLE);
  assign ev_reject   = accept && (!dyn_en || !hit);
  assign ev_same     = accept && dyn_en && hit && (hit_lvl == lvl_q);
  assign ev_go       = accept && dyn_en && hit && (hit_lvl != lvl_q);
  assign ramp_needed = ev_go && (hit_lvl == LVL_TOP) && base_fast && rate_fast && !tmr_ok;
  assign ramp_finish = (st_q == ST_RAMP) && tmr_expire;

  assign tmr_start = (ev_go && hit_lvl == LVL_MID && lvl_q != LVL_TOP) || ramp_needed;
  assign tmr_mark  = ev_go && hit_lvl == LVL_MID && lvl_q == LVL_TOP;
  assign tmr_clear = (ev_go && hit_lvl[LVL_W-1])
                   || (ev_go && hit_lvl == LVL_TOP && !ramp_needed)
                   || ramp_finish;

  dvfs_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (tmr_start),
    .mark_i   (tmr_mark),
    .clear_i  (tmr_clear),
    .dwell_i  (dwell_cycles),
    .ok_o     (tmr_ok),
    .expire_o (tmr_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= LVL_TOP;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= ev_same || (ev_go && !ramp_needed) || ramp_finish;
      err_q  <= ev_reject;
      if (ramp_needed) begin
        st_q  <= ST_RAMP;
        lvl_q <= LVL_MID;
      end else if (ev_go) begin
        lvl_q <= hit_lvl;
      end else if (ramp_finish) begin
        st_q  <= ST_IDLE;
        lvl_q <= LVL_TOP;
      end
    end
  end

  dvfs_out_sel u_out (
    .dyn_en (dyn_en),
    .lvl_i  (lvl_q),
    .desc_i (descs),
    .st_src (static_src),
    .st_div (static_div),
    .st_sel (static_sel),
    .src_o  (src_o),
    .div_o  (div_o),
    .sel_o  (sel_o)
  );

  assign lvl_o  = lvl_q;
  assign busy_o = (st_q == ST_RAMP);
  assign done_o = done_q;
  assign err_o  = err_q;

  // R8
  busy_mid_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> lvl_o == LVL_MID);

  // R8
  ramp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_needed |=> (busy_o && lvl_o == LVL_MID && !done_o));

  // R5
  reject_keeps_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> lvl_o == $past(lvl_o));

  // R10
  busy_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tmr_expire) |=> (!err_o && !done_o));

  // R4
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));
endmodule

// File: tb/dvfs_level_ctrl_test.sv
module dvfs_level_ctrl_test;
  localparam int PERIOD = 10;
  localparam int CW     = 25;
  localparam int DWELL  = 5;

  logic clk = 0, rst_n = 0;
  logic dyn_en = 0;
  logic [31:0] cfg_hi_word = 32'h2800_4200;
  logic [31:0] cfg_lo_word = 32'h8C00_C600;
  logic [1:0] static_src = 2'd2;
  logic [2:0] static_div = 3'd3;
  logic static_sel = 1'b1;
  logic base_fast = 1, rate_fast = 1;
  logic req_valid = 0;
  logic [2:0] req_div = 0;
  logic [CW-1:0] dwell_cycles = CW'(DWELL);
  logic [1:0] lvl_o, src_o;
  logic [2:0] div_o;
  logic sel_o, busy_o, done_o, err_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  dvfs_level_ctrl #(.CNT_W(CW)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  // Behavioural reference
  int m_lvl, m_trk, m_cnt, m_ramp, m_done, m_err;

  function automatic int fld(int lvl, int pos, int w);
    logic [31:0] word;
    int off;
    word = (lvl < 2) ? cfg_hi_word : cfg_lo_word;
    off  = (lvl % 2 == 0) ? 16 : 0;
    return int'((word >> (off + pos)) & ((32'd1 << w) - 1));
  endfunction

  always @(posedge clk) begin
    int nd, ne, tgt, old_trk;
    if (!rst_n) begin
      m_lvl = 0; m_trk = 0; m_cnt = 0; m_ramp = 0; m_done = 0; m_err = 0;
    end else begin
      nd = 0; ne = 0;
      if (m_ramp != 0) begin
        if (m_cnt + 1 >= DWELL) begin m_lvl = 0; m_trk = 0; m_ramp = 0; nd = 1; end
        else m_cnt++;
      end else begin
        old_trk = m_trk;
        if (m_trk == 1) begin
          if (m_cnt + 1 >= DWELL) m_trk = 2; else m_cnt++;
        end
        if (req_valid) begin
          if (!dyn_en) ne = 1;
          else begin
            tgt = -1;
            for (int i = 3; i >= 0; i--) if (fld(i, 13, 3) == int'(req_div)) tgt = i;
            if (tgt < 0) ne = 1;
            else if (tgt == m_lvl) nd = 1;
            else if (tgt == 1) begin
              if (m_lvl == 0) m_trk = 2; else begin m_trk = 1; m_cnt = 0; end
              m_lvl = 1; nd = 1;
            end else if (tgt == 0) begin
              if (base_fast && rate_fast && old_trk != 2) begin
                m_lvl = 1; m_trk = 1; m_cnt = 0; m_ramp = 1;
              end else begin m_lvl = 0; m_trk = 0; nd = 1; end
            end else begin m_lvl = tgt; m_trk = 0; nd = 1; end
          end
        end
      end
      m_done = nd; m_err = ne;
    end
  end

  task automatic fail_line(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) fail_line(tag, what, act, exp);
  endtask

  // Cycle-by-cycle comparison
  always @(negedge clk) begin
    int e_src, e_div, e_sel;
    bit bad;
    if (rst_n && !finished) begin
      e_src = dyn_en ? fld(m_lvl, 9, 2)  : int'(static_src);
      e_div = dyn_en ? fld(m_lvl, 13, 3) : int'(static_div);
      e_sel = dyn_en ? fld(m_lvl, 11, 1) : int'(static_sel);
      bad = 0;
      tests++;
      if (int'(lvl_o) != m_lvl) begin fail_line("R4", "lvl", lvl_o, m_lvl); bad = 1; end
      if (int'(src_o) != e_src) begin fail_line(dyn_en ? "R2" : "R3", "src", src_o, e_src); bad = 1; end
      if (int'(div_o) != e_div) begin fail_line(dyn_en ? "R2" : "R3", "div", div_o, e_div); bad = 1; end
      if (int'(sel_o) != e_sel) begin fail_line(dyn_en ? "R2" : "R3", "sel", sel_o, e_sel); bad = 1; end
      if (int'(busy_o) != m_ramp) begin fail_line("R8", "busy", busy_o, m_ramp); bad = 1; end
      if (int'(done_o) != m_done) begin fail_line("R4", "done", done_o, m_done); bad = 1; end
      if (int'(err_o) != m_err) begin fail_line("R5", "err", err_o, m_err); bad = 1; end
      if (bad) fails = fails + 0;
    end
  end

  task automatic req(int d);
    @(negedge clk); #1;
    req_valid = 1; req_div = 3'(d);
    @(negedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy_o) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    int n;
    idle(2);
    // R1
    chk("R1", "lvl in reset", lvl_o, 0);
    chk("R1", "busy in reset", busy_o, 0);
    rst_n = 1;
    idle(1);
    chk("R1", "done after reset", done_o, 0);
    // R3
    chk("R3", "static div", div_o, 3);
    chk("R3", "static src", src_o, 2);
    // R5 dynamic off
    req(4);
    chk("R5", "err with dyn off", err_o, 1);
    chk("R5", "lvl kept", lvl_o, 0);
    dyn_en = 1;
    idle(1);
    // R2
    chk("R2", "L0 div", div_o, 1);
    chk("R2", "L0 sel", sel_o, 1);
    // R6
    req(1);
    chk("R6", "done on same", done_o, 1);
    chk("R6", "lvl unchanged", lvl_o, 0);
    // R5 no match
    req(7);
    chk("R5", "err no match", err_o, 1);
    // R4
    req(4);
    chk("R4", "to L2", lvl_o, 2);
    chk("R2", "L2 src", src_o, 2);
    // R8 ramp from L2
    req(1);
    chk("R8", "busy on ramp", busy_o, 1);
    chk("R8", "mid level", lvl_o, 1);
    // R10 held request
    req_valid = 1; req_div = 3'd6;
    wait_busy(n);
    chk("R8", "busy length", n, DWELL);
    chk("R8", "reached L0", lvl_o, 0);
    chk("R8", "done at end", done_o, 1);
    idle(1);
    req_valid = 0;
    chk("R10", "held req taken", lvl_o, 3);
    // R7 run dwell from L3, then immediate L0 ramps
    req(2);
    req(1);
    chk("R7", "ramp while dwell running", busy_o, 1);
    wait_busy(n);
    // R7 mark from L0, then direct
    req(2);
    req(1);
    chk("R9", "direct after mark", lvl_o, 0);
    chk("R7", "no busy after mark", busy_o, 0);
    // R11 clear via L2
    req(2); req(4); req(1);
    chk("R11", "ramp after clear", busy_o, 1);
    wait_busy(n);
    // R7 dwell elapsed in background
    req(6); req(2); idle(DWELL + 3); req(1);
    chk("R7", "direct after elapsed dwell", busy_o, 0);
    chk("R7", "lvl after elapsed dwell", lvl_o, 0);
    // R9 slow base
    base_fast = 0;
    req(6); req(1);
    chk("R9", "direct slow base", lvl_o, 0);
    base_fast = 1; rate_fast = 0;
    req(6); req(1);
    chk("R9", "direct slow rate", lvl_o, 0);
    rate_fast = 1;
    // R4 first match priority: L3 divider now equals L1
    cfg_lo_word = 32'h8C00_4600;
    req(2);
    chk("R4", "lowest index wins", lvl_o, 1);
    // R3 back to static
    dyn_en = 0;
    idle(1);
    chk("R3", "static sel", sel_o, 1);
    chk("R3", "static div again", div_o, 3);
    idle(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule